// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low-order word offset inside a four-word group for a synchronous burst memory. At the start of a burst it captures the low bits of the supplied address when an address strobe is accepted. Two strobes can start a burst: one driven by a processor and one driven by a controller. After that, each rising clock edge that samples the active-low advance input low moves the offset to the next beat of the burst. The offset never carries out of its group. An upper-address block or a memory array can use the offset directly. A second output marks the fourth and final beat.

A static order input selects how the beats are visited. In linear order the offset counts upward modulo four from the loaded start. In interleaved order the offset is the loaded start XORed with a beat count that runs 0,1,2,3. A qualifying input from the surrounding chip-enable logic must be high for either strobe to load. The processor strobe is also gated by its own active-low enable.

Top module: `burst_addr_seq`

## Requirements
- R1: If `proc_stb_n`=0, `ce1_n`=0 and `load_ok_i`=1 at a rising edge, then after that edge `baddr_o` equals `addr_lo_i` and `final_beat_o` is 0.
- R2: If `ctrl_stb_n`=0 and `load_ok_i`=1 at a rising edge, then after that edge `baddr_o` equals `addr_lo_i` and `final_beat_o` is 0. This holds whatever the value of `ce1_n`.
- R3: When both strobes are low in the same cycle, a single load of `addr_lo_i` takes place and the processor strobe is the one acted on.
- R4: While `ce1_n`=1, a low `proc_stb_n` is ignored. With `ctrl_stb_n`=1 and `adv_n`=1 the outputs do not change.
- R5: While `load_ok_i`=0, neither strobe loads. With `adv_n`=1 the outputs do not change.
- R6: With `order_sel`=0 (linear), each edge that samples `adv_n`=0 without a load sets `baddr_o` to (previous `baddr_o` + 1) mod 4. A start of 2 therefore gives 2,3,0,1.
- R7: With `order_sel`=1 (interleaved), the beat k (0..3) after a load has `baddr_o` = start XOR k. A start of 1 gives 1,0,3,2. The strap is held static outside reset.
- R8: An edge with no load and `adv_n`=1 leaves `baddr_o` and `final_beat_o` unchanged.
- R9: An accepted strobe wins over a low `adv_n` in the same cycle, and the burst restarts at the new start.
- R10: `final_beat_o` is 1 exactly on the fourth beat. A further advance wraps to the start offset with `final_beat_o`=0.
- R11: While `rst_n`=0, `baddr_o`=0 and `final_beat_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_lo_i | input | 2 | Low address bits captured as the burst start |
| proc_stb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| ce1_n | input | 1 | Active-low enable that gates the processor strobe |
| load_ok_i | input | 1 | High when the chip-select logic allows a load |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_sel | input | 1 | Static order strap: 0 linear, 1 interleaved |
| baddr_o | output | 2 | Current burst offset |
| final_beat_o | output | 1 | High on the fourth beat of the burst |

## Verification
The assertions assume that `order_sel` changes only while `rst_n` is low. One property checks this assumption. The bench therefore sets the strap and then pulses reset before every burst in a new order. All other inputs are driven on the falling edge and held for a full cycle, so each rising edge samples settled values. The properties derive load acceptance from the strobe, enable and qualifying ports alone. They then check the outputs one edge later, for loading, masking, holding, linear stepping and final-beat wrap.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_PROC = 2'd1,
      LD_CTRL = 2'd2
   } ld_src_e;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;

endpackage

// File: rtl/bseq_strobe_qual.sv
module bseq_strobe_qual
   import bseq_pkg::*;
(
   input  logic    proc_stb_n,
   input  logic    ctrl_stb_n,
   input  logic    ce1_n,
   input  logic    load_ok_i,
   output ld_src_e src_o
);

   logic proc_take;
   logic ctrl_take;

   // processor strobe needs its own enable as well as the chip-select qualifier
   assign proc_take = ~proc_stb_n & ~ce1_n & load_ok_i;
   assign ctrl_take = ~ctrl_stb_n & load_ok_i;

   always_comb begin
      if (proc_take)      src_o = LD_PROC;
      else if (ctrl_take) src_o = LD_CTRL;
      else                src_o = LD_NONE;
   end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [BEAT_BITS-1:0] start_i,
   input  logic                 adv_n,
   output logic [BEAT_BITS-1:0] start_q,
   output logic [BEAT_BITS-1:0] beat_q,
   output logic                 last_o
);

   localparam logic [BEAT_BITS-1:0] BEAT_ONE  = BEAT_BITS'(1);
   localparam logic [BEAT_BITS-1:0] BEAT_LAST = {BEAT_BITS{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         beat_q  <= '0;
      end else if (load_i) begin
         start_q <= start_i;
         beat_q  <= '0;
      end else if (!adv_n) begin
         beat_q  <= beat_q + BEAT_ONE;   // wraps inside the group
      end
   end

   assign last_o = (beat_q == BEAT_LAST);

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
   import bseq_pkg::*;
#(
   parameter int BEAT_BITS = 2
) (
   input  logic [BEAT_BITS-1:0] start_i,
   input  logic [BEAT_BITS-1:0] beat_i,
   input  order_e               order_i,
   output logic [BEAT_BITS-1:0] addr_o
);

   logic [BEAT_BITS-1:0] lin_addr;
   logic [BEAT_BITS-1:0] xor_addr;

   assign lin_addr = start_i + beat_i;

   for (genvar b = 0; b < BEAT_BITS; b++) begin : g_xor_bit
      assign xor_addr[b] = start_i[b] ^ beat_i[b];
   end

   assign addr_o = (order_i == ORD_XOR) ? xor_addr : lin_addr;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bseq_pkg::*;
#(
   parameter int BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BEAT_BITS-1:0] addr_lo_i,
   input  logic                 proc_stb_n,
   input  logic                 ctrl_stb_n,
   input  logic                 ce1_n,
   input  logic                 load_ok_i,
   input  logic                 adv_n,
   input  logic                 order_sel,
   output logic [BEAT_BITS-1:0] baddr_o,
   output logic                 final_beat_o
);

   localparam int BEATS = 1 << BEAT_BITS;

   if (BEAT_BITS < 1 || BEAT_BITS > 4) begin : g_bad_width
      $error("burst_addr_seq: BEAT_BITS must lie in 1..4");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("burst_addr_seq: a burst needs at least two beats");
   end

   ld_src_e              ld_src;
   logic                 load;
   logic [BEAT_BITS-1:0] start_q;
   logic [BEAT_BITS-1:0] beat_q;
   order_e               order;

   assign order = order_e'(order_sel);

   bseq_strobe_qual u_qual (
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .ce1_n      (ce1_n),
      .load_ok_i  (load_ok_i),
      .src_o      (ld_src)
   );

   assign load = (ld_src != LD_NONE);

   bseq_beat_ctr #(.BEAT_BITS(BEAT_BITS)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .start_i (addr_lo_i),
      .adv_n   (adv_n),
      .start_q (start_q),
      .beat_q  (beat_q),
      .last_o  (final_beat_o)
   );

   bseq_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
      .start_i (start_q),
      .beat_i  (beat_q),
      .order_i (order),
      .addr_o  (baddr_o)
   );

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
   parameter int BEAT_BITS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [BEAT_BITS-1:0] addr_lo_i,
   input logic                 proc_stb_n,
   input logic                 ctrl_stb_n,
   input logic                 ce1_n,
   input logic                 load_ok_i,
   input logic                 adv_n,
   input logic                 order_sel,
   input logic [BEAT_BITS-1:0] baddr_o,
   input logic                 final_beat_o
);

   logic proc_ok;
   logic ctrl_ok;
   logic any_ld;

   assign proc_ok = !proc_stb_n && !ce1_n && load_ok_i;
   assign ctrl_ok = !ctrl_stb_n && load_ok_i;
   assign any_ld  = proc_ok || ctrl_ok;

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      any_ld |=> (baddr_o == $past(addr_lo_i)) && !final_beat_o); // R1

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_ok && ce1_n |=> baddr_o == $past(addr_lo_i)); // R2

   AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && !ctrl_stb_n && load_ok_i) |=> baddr_o == $past(addr_lo_i)); // R3

   AST_CE1_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && ce1_n && ctrl_stb_n && adv_n) |=> $stable(baddr_o) && $stable(final_beat_o)); // R4

   AST_QUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_ok_i && adv_n) |=> $stable(baddr_o) && $stable(final_beat_o)); // R5

   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ld && !adv_n && !order_sel) |=> baddr_o == BEAT_BITS'($past(baddr_o) + 1'b1)); // R6

   AST_STRAP_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(order_sel)); // R7

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ld && adv_n) |=> $stable(baddr_o) && $stable(final_beat_o)); // R8

   AST_LOAD_OVER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (any_ld && !adv_n) |=> !final_beat_o && baddr_o == $past(addr_lo_i)); // R9

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ld && !adv_n && final_beat_o) |=> !final_beat_o); // R10

endmodule

bind burst_addr_seq bseq_checker #(.BEAT_BITS(BEAT_BITS)) u_chk (.*);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr_lo_i = 2'd0;
   logic       proc_stb_n = 1'b1;
   logic       ctrl_stb_n = 1'b1;
   logic       ce1_n = 1'b1;
   logic       load_ok_i = 1'b0;
   logic       adv_n = 1'b1;
   logic       order_sel = 1'b0;
   logic [1:0] baddr_o;
   logic       final_beat_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   burst_addr_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_lo_i    (addr_lo_i),
      .proc_stb_n   (proc_stb_n),
      .ctrl_stb_n   (ctrl_stb_n),
      .ce1_n        (ce1_n),
      .load_ok_i    (load_ok_i),
      .adv_n        (adv_n),
      .order_sel    (order_sel),
      .baddr_o      (baddr_o),
      .final_beat_o (final_beat_o)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle on the falling edge, then sample just after the rising edge
   task automatic step(bit pn, bit cn, bit c1n, bit ok, bit an, logic [1:0] a);
      @(negedge clk);
      proc_stb_n = pn; ctrl_stb_n = cn; ce1_n = c1n;
      load_ok_i = ok; adv_n = an; addr_lo_i = a;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0);
   endtask

   task automatic restart(bit mode);
      @(negedge clk);
      rst_n = 1'b0; order_sel = mode;
      proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int ref_addr(bit mode, int s, int k);
      return mode ? ((s ^ k) & 3) : ((s + k) & 3);
   endfunction

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R11 addr", baddr_o, 0);
      chk("R11 final", final_beat_o, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_burst(bit mode, int s, bit use_proc);
      string tag;
      tag = mode ? "R7" : "R6";
      restart(mode);
      if (use_proc) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'(s));
      else          step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'(s));
      chk(use_proc ? "R1 load" : "R2 load", baddr_o, s);
      chk(use_proc ? "R1 final" : "R2 final", final_beat_o, 0);
      for (int k = 1; k < 4; k++) begin
         step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
         chk(tag, baddr_o, ref_addr(mode, s, k));
         chk("R10 final", final_beat_o, (k == 3) ? 1 : 0);
      end
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      chk("R10 wrap", baddr_o, s);
      chk("R10 wrap final", final_beat_o, 0);
   endtask

   task automatic t_both();
      restart(1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
      chk("R3 both strobes", baddr_o, 3);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      chk("R3 single load", baddr_o, 0);
      // processor strobe masked, controller strobe still loads
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2);
      chk("R3 ctrl when proc masked", baddr_o, 2);
   endtask

   task automatic t_ce1_block();
      restart(1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
      chk("R4 masked addr", baddr_o, 2);
      chk("R4 masked final", final_beat_o, 0);
   endtask

   task automatic t_qual_low();
      restart(1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2);
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1);
      chk("R5 ctrl blocked", baddr_o, 2);
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);
      chk("R5 proc blocked", baddr_o, 2);
   endtask

   task automatic t_hold();
      restart(1'b1);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      for (int i = 0; i < 3; i++) begin
         idle();
         chk("R8 hold addr", baddr_o, 2);
         chk("R8 hold final", final_beat_o, 1);
      end
   endtask

   task automatic t_load_over_adv();
      restart(1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
      chk("R9 reload addr", baddr_o, 1);
      chk("R9 reload final", final_beat_o, 0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
      chk("R9 next beat", baddr_o, 2);
   endtask

   initial begin
      t_reset();
      for (int s = 0; s < 4; s++) t_burst(1'b0, s, 1'b1);
      for (int s = 0; s < 4; s++) t_burst(1'b1, s, 1'b0);
      t_both();
      t_ce1_block();
      t_qual_low();
      t_hold();
      t_load_over_adv();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule